// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block produces the instruction fetch address once per clock. By default the address advances by one. Decoded control fields from the current instruction can redirect it. A conditional jump or call goes to a target address. A conditional return resumes after the most recent call. A loop-setup command opens a hardware loop.

A hardware loop needs no branch instruction at its tail. When the loop-setup command arrives, the block pushes three things:

- the loop start (the address following the command) and the last body address onto a loop stack;
- the iteration count onto a parallel counter stack.

Whenever the fetch address equals the last body address of the innermost loop, the block chooses the next address itself. It returns to the loop start and decrements the counter, or it leaves the loop when the counter has run out. Loops nest up to the depth of the loop stack.

Calls and returns use a separate return-address stack. An attempt to push onto a full stack or pop from an empty one raises a one-cycle error flag. A stall input freezes every register. The controller has two states:

- `ST_FLAT`: no loop is open.
- `ST_LOOP`: at least one loop is open, and the loop-end compare is armed.

It moves from `ST_FLAT` to `ST_LOOP` when a loop-setup command is accepted. It moves from `ST_LOOP` back to `ST_FLAT` when the last open loop pops. Every other case holds the state.

Top module: `zol_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fetch_addr` is 0 and both error flags are 0.
- R2: With no control field active and no loop end reached, each cycle `fetch_addr` becomes the previous address plus one, modulo 2^14 (16383 is followed by 0).
- R3: `jump_en` with `cond_true` high makes the next `fetch_addr` equal to `target_addr`. With `cond_true` low, the flow is sequential.
- R4: `call_en` with `cond_true` pushes `fetch_addr`+1 and goes to `target_addr` in the next cycle. `ret_en` with `cond_true` pops that address into `fetch_addr` in the next cycle. Either one with `cond_true` low is sequential.
- R5: `loop_en` at address A with last address E and count N>1 makes the fetch sequence run A+1..E exactly N times, then continue at E+1, with no control field driven after the setup.
- R6: A loop count of 0 or 1 runs the body A+1..E once.
- R7: Loops nest: an inner loop opened inside an outer body completes its own count on every outer pass, and the outer loop still closes correctly.
- R8: The return stack holds 16 entries. A 17th unreturned call raises `stk_overflow` in the next cycle and is dropped, so the flow is sequential. A return on an empty stack raises `stk_underflow` in the next cycle and the flow is sequential. Each flag lasts one cycle.
- R9: The loop and counter stacks hold 4 entries. A fifth loop setup raises `stk_overflow` in the next cycle and is ignored, so no loop-back ever occurs at its last address.
- R10: While `stall` is high, `fetch_addr`, all stacks and the loop counters hold, and both flags are 0. The pending loop-end decision is taken once, after the stall ends.
- R11: Priority among simultaneous fields is jump, then call, then return, then loop setup, then the automatic loop-end redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze address and all stacks |
| cond_true | input | 1 | Condition result for jump, call, return |
| jump_en | input | 1 | Conditional jump field |
| call_en | input | 1 | Conditional call field |
| ret_en | input | 1 | Conditional return field |
| loop_en | input | 1 | Loop-setup field |
| target_addr | input | 14 | Jump or call destination |
| loop_last | input | 14 | Last body address of the new loop |
| loop_count | input | 16 | Iteration count of the new loop |
| fetch_addr | output | 14 | Current fetch address |
| stk_overflow | output | 1 | Push onto a full stack was refused |
| stk_underflow | output | 1 | Return with empty return stack |

## Verification
The bench builds the block with its default parameters. These are a 14-bit address, a 16-bit count, a 16-entry return stack and a 4-entry loop stack. With these values, 17 nested calls reach return-stack overflow, and a fifth loop setup reaches loop-stack overflow, within a few dozen cycles. A single jump to 16383 exposes the address wrap. Loops are kept to a handful of addresses and counts of 0 to 3, so that every loop-back and exit address can be listed by hand, including a two-level nest where the inner loop restarts on each outer pass.

// File: rtl/zol_pkg.sv
package zol_pkg;

    typedef enum logic {
        ST_FLAT,
        ST_LOOP
    } seq_state_e;

    typedef enum logic [2:0] {
        FLOW_HOLD,
        FLOW_SEQ,
        FLOW_JUMP,
        FLOW_RET,
        FLOW_LOOPBACK
    } flow_e;

endpackage

// File: rtl/zol_lifo.sv
module zol_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         wr_top,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty,
    output logic         single
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0] level_q;
    logic [W-1:0]     mem_q [DEPTH];
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] push_idx;

    assign top_idx  = IDX_W'(level_q - LVL_W'(1));
    assign push_idx = IDX_W'(level_q);
    assign full     = (level_q == LVL_W'(DEPTH));
    assign empty    = (level_q == '0);
    assign single   = (level_q == LVL_W'(1));
    assign top      = empty ? '0 : mem_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (push && !full) begin
            level_q <= level_q + LVL_W'(1);
        end else if (pop && !empty) begin
            level_q <= level_q - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem_q[push_idx] <= din;
        end else if (wr_top && !empty) begin
            mem_q[top_idx] <= din;
        end
    end

endmodule

// File: rtl/zol_addr_mux.sv
module zol_addr_mux
    import zol_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  flow_e             flow,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] loop_start,
    output logic [ADDR_W-1:0] next_pc
);
    always_comb begin
        unique case (flow)
            FLOW_HOLD:     next_pc = cur_pc;
            FLOW_JUMP:     next_pc = target;
            FLOW_RET:      next_pc = ret_addr;
            FLOW_LOOPBACK: next_pc = loop_start;
            default:       next_pc = cur_pc + ADDR_W'(1);
        endcase
    end

endmodule

// File: rtl/zol_seq.sv
module zol_seq
    import zol_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int CNT_W      = 16,
    parameter int PC_DEPTH   = 16,
    parameter int LOOP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              cond_true,
    input  logic              jump_en,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic              loop_en,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] loop_last,
    input  logic [CNT_W-1:0]  loop_count,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              stk_overflow,
    output logic              stk_underflow
);
    localparam int FRAME_W = 2 * ADDR_W;

    seq_state_e state_q, state_d;
    flow_e      flow;

    logic [ADDR_W-1:0]  pc_q, pc_inc, next_pc;
    logic [ADDR_W-1:0]  ret_top, loop_start, loop_end;
    logic [FRAME_W-1:0] frame_top;
    logic [CNT_W-1:0]   cnt_top, cnt_din;
    logic pc_push, pc_pop, loop_push, loop_pop, cnt_wr;
    logic pc_full, pc_empty, pc_single;
    logic loop_full, loop_empty, loop_single;
    logic cnt_full, cnt_empty, cnt_single;
    logic ovf_d, unf_d, ovf_q, unf_q;
    logic at_end;

    assign pc_inc     = pc_q + ADDR_W'(1);
    assign loop_start = frame_top[FRAME_W-1:ADDR_W];
    assign loop_end   = frame_top[ADDR_W-1:0];
    assign at_end     = (state_q == ST_LOOP) && !loop_empty && !cnt_empty
                        && (pc_q == loop_end);
    assign cnt_din    = loop_push ? loop_count : cnt_top - CNT_W'(1);

    zol_lifo #(.W(ADDR_W), .DEPTH(PC_DEPTH)) u_pc_stk (
        .clk(clk), .rst_n(rst_n), .push(pc_push), .pop(pc_pop),
        .wr_top(1'b0), .din(pc_inc), .top(ret_top),
        .full(pc_full), .empty(pc_empty), .single(pc_single)
    );

    zol_lifo #(.W(FRAME_W), .DEPTH(LOOP_DEPTH)) u_loop_stk (
        .clk(clk), .rst_n(rst_n), .push(loop_push), .pop(loop_pop),
        .wr_top(1'b0), .din({pc_inc, loop_last}), .top(frame_top),
        .full(loop_full), .empty(loop_empty), .single(loop_single)
    );

    zol_lifo #(.W(CNT_W), .DEPTH(LOOP_DEPTH)) u_cnt_stk (
        .clk(clk), .rst_n(rst_n), .push(loop_push), .pop(loop_pop),
        .wr_top(cnt_wr), .din(cnt_din), .top(cnt_top),
        .full(cnt_full), .empty(cnt_empty), .single(cnt_single)
    );

    zol_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .flow(flow), .cur_pc(pc_q), .target(target_addr),
        .ret_addr(ret_top), .loop_start(loop_start), .next_pc(next_pc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLAT;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLAT: if (loop_push)                state_d = ST_LOOP;
            ST_LOOP: if (loop_pop && loop_single) state_d = ST_FLAT;
            default: state_d = ST_FLAT;
        endcase
    end

    // flow and stack controls, fixed priority
    always_comb begin
        flow      = FLOW_SEQ;
        pc_push   = 1'b0;
        pc_pop    = 1'b0;
        loop_push = 1'b0;
        loop_pop  = 1'b0;
        cnt_wr    = 1'b0;
        ovf_d     = 1'b0;
        unf_d     = 1'b0;
        if (stall) begin
            flow = FLOW_HOLD;
        end else if (jump_en && cond_true) begin
            flow = FLOW_JUMP;
        end else if (call_en && cond_true) begin
            if (pc_full) ovf_d = 1'b1;
            else begin
                pc_push = 1'b1;
                flow    = FLOW_JUMP;
            end
        end else if (ret_en && cond_true) begin
            if (pc_empty) unf_d = 1'b1;
            else begin
                pc_pop = 1'b1;
                flow   = FLOW_RET;
            end
        end else if (loop_en) begin
            if (loop_full || cnt_full) ovf_d = 1'b1;
            else                       loop_push = 1'b1;
        end else if (at_end) begin
            if (cnt_top > CNT_W'(1)) begin
                flow   = FLOW_LOOPBACK;
                cnt_wr = 1'b1;
            end else begin
                loop_pop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            pc_q  <= next_pc;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

    assign fetch_addr    = pc_q;
    assign stk_overflow  = ovf_q;
    assign stk_underflow = unf_q;

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              cond_true,
    input logic              jump_en,
    input logic              call_en,
    input logic              ret_en,
    input logic              loop_en,
    input logic [ADDR_W-1:0] target_addr,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              stk_overflow,
    input logic              stk_underflow,
    input logic              at_end,
    input logic [ADDR_W-1:0] loop_start,
    input logic [CNT_W-1:0]  cnt_top,
    input logic              loop_single,
    input logic              cnt_single,
    input logic              loop_full,
    input logic              cnt_full,
    input logic              pc_single,
    input logic              pc_empty
);
    logic no_ctrl;
    assign no_ctrl = !jump_en && !call_en && !ret_en && !loop_en;

    assert_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && no_ctrl && !at_end) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && jump_en && cond_true) |=> fetch_addr == $past(target_addr));

    assert_ret_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !jump_en && !call_en && ret_en && cond_true && pc_single) |=> pc_empty);

    assert_loopback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && no_ctrl && at_end && cnt_top > CNT_W'(1))
        |=> fetch_addr == $past(loop_start));

    assert_stacks_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_single == cnt_single) && (loop_full == cnt_full));

    // covers the loop-stack case of R9 as well
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_overflow |-> $past(!stall && ((call_en && cond_true) || loop_en)));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_underflow |-> $past(!stall && ret_en && cond_true));

    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(fetch_addr) && !stk_overflow && !stk_underflow));

endmodule

bind zol_seq zol_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .cond_true(cond_true),
    .jump_en(jump_en), .call_en(call_en), .ret_en(ret_en), .loop_en(loop_en),
    .target_addr(target_addr), .fetch_addr(fetch_addr),
    .stk_overflow(stk_overflow), .stk_underflow(stk_underflow),
    .at_end(at_end), .loop_start(loop_start), .cnt_top(cnt_top),
    .loop_single(loop_single), .cnt_single(cnt_single),
    .loop_full(loop_full), .cnt_full(cnt_full),
    .pc_single(pc_single), .pc_empty(pc_empty)
);

// File: tb/zol_seq_tb.sv
`timescale 1ns/1ps
module zol_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0, cond_true = 1'b0;
    logic        jump_en = 1'b0, call_en = 1'b0, ret_en = 1'b0, loop_en = 1'b0;
    logic [13:0] target_addr = '0, loop_last = '0;
    logic [15:0] loop_count = '0;
    logic [13:0] fetch_addr;
    logic        stk_overflow, stk_underflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    zol_seq #(.ADDR_W(14), .CNT_W(16), .PC_DEPTH(16), .LOOP_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .cond_true(cond_true),
        .jump_en(jump_en), .call_en(call_en), .ret_en(ret_en), .loop_en(loop_en),
        .target_addr(target_addr), .loop_last(loop_last), .loop_count(loop_count),
        .fetch_addr(fetch_addr), .stk_overflow(stk_overflow),
        .stk_underflow(stk_underflow)
    );

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        stall = 0; cond_true = 0; jump_en = 0; call_en = 0; ret_en = 0; loop_en = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic op_loop(int last, int cnt);
        loop_en = 1; loop_last = 14'(last); loop_count = 16'(cnt);
        tick(); idle();
    endtask

    // walk a list of expected addresses; re-open an inner loop whenever redo_pc is fetched
    task automatic walk(string req, int expq[$], int redo_pc, int rlast, int rcnt);
        foreach (expq[i]) begin
            chk(req, fetch_addr, expq[i]);
            if (fetch_addr == 14'(redo_pc)) op_loop(rlast, rcnt);
            else tick();
        end
    endtask

    task automatic t_reset();   // R1, R2
        do_reset();
        chk("R1 addr", fetch_addr, 0);
        chk("R1 ovf", stk_overflow, 0);
        chk("R1 unf", stk_underflow, 0);
        tick();
        chk("R2 step", fetch_addr, 1);
    endtask

    task automatic t_jump();    // R3, R2 wrap
        do_reset();
        jump_en = 1; target_addr = 100; cond_true = 0; tick(); idle();
        chk("R3 not taken", fetch_addr, 1);
        jump_en = 1; target_addr = 100; cond_true = 1; tick(); idle();
        chk("R3 taken", fetch_addr, 100);
        jump_en = 1; target_addr = 16383; cond_true = 1; tick(); idle();
        chk("R3 top", fetch_addr, 16383);
        tick();
        chk("R2 wrap", fetch_addr, 0);
    endtask

    task automatic t_call();    // R4, R11
        do_reset();
        tick();
        call_en = 1; target_addr = 20; cond_true = 1; tick(); idle();
        chk("R4 call", fetch_addr, 20);
        call_en = 1; target_addr = 40; cond_true = 0; tick(); idle();
        chk("R4 call false", fetch_addr, 21);
        ret_en = 1; cond_true = 0; tick(); idle();
        chk("R4 ret false", fetch_addr, 22);
        ret_en = 1; cond_true = 1; tick(); idle();
        chk("R4 ret", fetch_addr, 2);
        chk("R4 no flag", stk_underflow, 0);
        jump_en = 1; call_en = 1; target_addr = 77; cond_true = 1; tick(); idle();
        chk("R11 jump first", fetch_addr, 77);
        ret_en = 1; cond_true = 1; tick(); idle();
        chk("R11 no push by jump", stk_underflow, 1);
    endtask

    task automatic t_loop();    // R5
        do_reset();
        op_loop(3, 3);
        walk("R5 body", '{1, 2, 3, 1, 2, 3, 1, 2, 3, 4, 5}, -1, 0, 0);
    endtask

    task automatic t_short();   // R6
        do_reset();
        op_loop(2, 1);
        walk("R6 count1", '{1, 2, 3, 4}, -1, 0, 0);
        do_reset();
        op_loop(2, 0);
        walk("R6 count0", '{1, 2, 3, 4}, -1, 0, 0);
    endtask

    task automatic t_nested();  // R7
        do_reset();
        op_loop(6, 2);
        walk("R7 nest", '{1, 2, 3, 2, 3, 4, 5, 6, 1, 2, 3, 2, 3, 4, 5, 6, 7, 8}, 1, 3, 2);
    endtask

    task automatic t_pc_ovf();  // R8
        do_reset();
        for (int i = 0; i < 16; i++) begin
            call_en = 1; target_addr = 50; cond_true = 1; tick(); idle();
            chk("R8 fill", fetch_addr, 50);
        end
        call_en = 1; target_addr = 90; cond_true = 1; tick(); idle();
        chk("R8 dropped call", fetch_addr, 51);
        chk("R8 ovf flag", stk_overflow, 1);
        tick();
        chk("R8 ovf pulse", stk_overflow, 0);
        for (int i = 0; i < 16; i++) begin
            ret_en = 1; cond_true = 1; tick(); idle();
            chk("R8 drain", fetch_addr, (i < 15) ? 51 : 1);
        end
        ret_en = 1; cond_true = 1; tick(); idle();
        chk("R8 unf addr", fetch_addr, 2);
        chk("R8 unf flag", stk_underflow, 1);
        tick();
        chk("R8 unf pulse", stk_underflow, 0);
    endtask

    task automatic t_loop_ovf(); // R9
        do_reset();
        for (int i = 0; i < 4; i++) op_loop(1000, 5);
        chk("R9 fill", stk_overflow, 0);
        op_loop(6, 2);
        chk("R9 ovf flag", stk_overflow, 1);
        walk("R9 ignored", '{5, 6, 7, 8}, -1, 0, 0);
    endtask

    task automatic t_stall();   // R10
        do_reset();
        stall = 1; jump_en = 1; target_addr = 100; cond_true = 1;
        tick(); tick();
        chk("R10 frozen", fetch_addr, 0);
        stall = 0; tick(); idle();
        chk("R10 resume", fetch_addr, 100);
        do_reset();
        op_loop(2, 2);
        tick();
        chk("R10 at end", fetch_addr, 2);
        stall = 1; tick(); tick(); tick(); idle();
        chk("R10 held end", fetch_addr, 2);
        walk("R10 loop once", '{2, 1, 2, 3}, -1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_jump();
        t_call();
        t_loop();
        t_short();
        t_nested();
        t_pc_ovf();
        t_loop_ovf();
        t_stall();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule